// File: doc/BRIEF.md
# General-Purpose Register Overlay with Debug Pin Mux

This block sits between a small 8-bit processor core and the chip pins. While the overlay enable strap is high, it places eight 8-bit scratch registers over the top eight locations of the 7-bit address space. A read from one of those locations returns the register's contents to the core in place of the external read data. A write on the clock edge updates the register. The write is still presented to the outside world, because the write-enable pin is never masked.

The same block drives the address pins. A 3-bit debug select either passes the core's address through or replaces it with a piece of the core's internal state: the accumulator, the memory pointer, the program counter, the instruction register, the condition flags or the control-state code. This lets running silicon be observed without a debugger. The write-enable level always occupies the top pin. The core itself is outside this block and appears only as its bus and state signals.

Top module: `gpr_overlay_dbg`

## Requirements
- R1: Reset (rst_n low) clears all eight registers to 0x00 and takes priority over any write presented during reset.
- R2: With ovl_en high, addresses 0x78..0x7F select registers 0..7 in ascending order. core_rdata shows the selected register combinationally in the same cycle. A rising clock edge with core_we high stores core_wdata into it, and the new value is readable from the next cycle on.
- R3: With ovl_en low, core_rdata equals ext_rdata for every address, and a write to 0x78..0x7F leaves the registers unchanged.
- R4: With ovl_en high and an address below 0x78, core_rdata equals ext_rdata and a write leaves the registers unchanged.
- R5: pin_out[7] equals core_we for every dbg_sel value, so writes to mapped registers still reach the external bus.
- R6: dbg_sel = 3'b000 drives core_addr[6:0] onto pin_out[6:0].
- R7: dbg_sel = 3'b001 drives st_acc[6:0] onto pin_out[6:0].
- R8: dbg_sel = 3'b010 drives st_acc[7] onto pin_out[0], with pin_out[6:1] zero.
- R9: dbg_sel = 3'b011 drives st_mptr[6:0] onto pin_out[6:0].
- R10: dbg_sel = 3'b100 drives st_pc[6:0], and dbg_sel = 3'b101 drives st_ir[6:0], onto pin_out[6:0].
- R11: dbg_sel = 3'b110 drives st_ccr[1:0] onto pin_out[1:0] with pin_out[6:2] zero, and dbg_sel = 3'b111 drives st_cu[6:0] onto pin_out[6:0].

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| ovl_en | input | 1 | Strap enabling the register overlay |
| dbg_sel | input | 3 | Selects what appears on pin_out[6:0] |
| core_addr | input | 7 | Address issued by the core |
| core_we | input | 1 | Write strobe from the core |
| core_wdata | input | 8 | Write data from the core |
| ext_rdata | input | 8 | Read data from the external bus |
| core_rdata | output | 8 | Read data returned to the core |
| st_acc | input | 8 | Core accumulator |
| st_mptr | input | 8 | Core memory pointer |
| st_pc | input | 8 | Core program counter |
| st_ir | input | 8 | Core instruction register |
| st_ccr | input | 2 | Core condition flags |
| st_cu | input | 7 | Core control-state code |
| pin_out | output | 8 | Pins: bit 7 write enable, bits 6:0 address or debug value |

## Verification
Read data and every pin value are combinational, so they are due in the same cycle as the inputs that cause them. A register write takes effect at the rising edge and is first readable in the following cycle. The bench changes inputs at the falling edge and samples outputs one nanosecond later, well before the next rising edge. Its reference model of the eight registers is updated only after that sample, so each comparison sees exactly the writes from earlier edges.

// File: rtl/ovl_pkg.sv
package ovl_pkg;
    localparam int OVL_DATA_W = 8;
    localparam int OVL_ADDR_W = 7;
    localparam int OVL_NREG   = 8;
    localparam int OVL_CCR_W  = 2;
    localparam int OVL_CU_W   = 7;
    localparam int OVL_SEL_W  = 3;

    typedef enum logic [OVL_SEL_W-1:0] {
        DBG_ADDR    = 3'd0,
        DBG_ACC_LO  = 3'd1,
        DBG_ACC_MSB = 3'd2,
        DBG_MPTR    = 3'd3,
        DBG_PC      = 3'd4,
        DBG_IR      = 3'd5,
        DBG_CCR     = 3'd6,
        DBG_CU      = 3'd7
    } dbg_sel_e;
endpackage

// File: rtl/ovl_decode.sv
module ovl_decode #(
    parameter int ADDR_W = 7,
    parameter int NREG   = 8,
    localparam int IDX_W = $clog2(NREG)
) (
    input  logic              en,
    input  logic [ADDR_W-1:0] addr,
    output logic              hit,
    output logic [IDX_W-1:0]  idx
);
    localparam int BASE = (1 << ADDR_W) - NREG;
    localparam logic [ADDR_W-1:0] BASE_A = BASE[ADDR_W-1:0];

    logic [ADDR_W-1:0] offset;

    always_comb begin
        offset = addr - BASE_A;
        idx    = offset[IDX_W-1:0];
        hit    = en && (addr >= BASE_A);
    end
endmodule

// File: rtl/ovl_regfile.sv
module ovl_regfile #(
    parameter int DATA_W = 8,
    parameter int NREG   = 8,
    localparam int IDX_W = $clog2(NREG)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [IDX_W-1:0]  idx,
    input  logic [DATA_W-1:0] wr_data,
    output logic [DATA_W-1:0] rd_data
);
    typedef struct packed {
        logic [NREG-1:0][DATA_W-1:0] regs;
    } rf_state_t;

    rf_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        for (int i = 0; i < NREG; i++) begin
            if (wr_en && (idx == IDX_W'(i))) begin
                st_d.regs[i] = wr_data;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign rd_data = st_q.regs[idx];
endmodule

// File: rtl/ovl_dbg_mux.sv
module ovl_dbg_mux
    import ovl_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int ADDR_W = 7,
    parameter int CCR_W  = 2,
    parameter int CU_W   = 7
) (
    input  logic [OVL_SEL_W-1:0] sel,
    input  logic [ADDR_W-1:0]    addr,
    input  logic [DATA_W-1:0]    acc,
    input  logic [DATA_W-1:0]    mptr,
    input  logic [DATA_W-1:0]    pc,
    input  logic [DATA_W-1:0]    ir,
    input  logic [CCR_W-1:0]     ccr,
    input  logic [CU_W-1:0]      cu,
    output logic [ADDR_W-1:0]    dout
);
    logic [ADDR_W-1:0] msb_ext;
    logic [ADDR_W-1:0] ccr_ext;
    logic [ADDR_W-1:0] cu_ext;

    always_comb begin
        msb_ext    = '0;
        msb_ext[0] = acc[DATA_W-1];
        ccr_ext    = '0;
        ccr_ext[CCR_W-1:0] = ccr;
        cu_ext     = '0;
        cu_ext[CU_W-1:0]   = cu;
        unique case (dbg_sel_e'(sel))
            DBG_ADDR:    dout = addr;
            DBG_ACC_LO:  dout = acc[ADDR_W-1:0];
            DBG_ACC_MSB: dout = msb_ext;
            DBG_MPTR:    dout = mptr[ADDR_W-1:0];
            DBG_PC:      dout = pc[ADDR_W-1:0];
            DBG_IR:      dout = ir[ADDR_W-1:0];
            DBG_CCR:     dout = ccr_ext;
            DBG_CU:      dout = cu_ext;
            default:     dout = addr;
        endcase
    end
endmodule

// File: rtl/gpr_overlay_dbg.sv
module gpr_overlay_dbg
    import ovl_pkg::*;
#(
    parameter int DATA_W = OVL_DATA_W,
    parameter int ADDR_W = OVL_ADDR_W,
    parameter int NREG   = OVL_NREG,
    parameter int CCR_W  = OVL_CCR_W,
    parameter int CU_W   = OVL_CU_W
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 ovl_en,
    input  logic [OVL_SEL_W-1:0] dbg_sel,
    input  logic [ADDR_W-1:0]    core_addr,
    input  logic                 core_we,
    input  logic [DATA_W-1:0]    core_wdata,
    input  logic [DATA_W-1:0]    ext_rdata,
    output logic [DATA_W-1:0]    core_rdata,
    input  logic [DATA_W-1:0]    st_acc,
    input  logic [DATA_W-1:0]    st_mptr,
    input  logic [DATA_W-1:0]    st_pc,
    input  logic [DATA_W-1:0]    st_ir,
    input  logic [CCR_W-1:0]     st_ccr,
    input  logic [CU_W-1:0]      st_cu,
    output logic [ADDR_W:0]      pin_out
);
    localparam int IDX_W = $clog2(NREG);

    logic              hit;
    logic [IDX_W-1:0]  idx;
    logic [DATA_W-1:0] rf_rdata;
    logic [ADDR_W-1:0] dbg_out;

    ovl_decode #(.ADDR_W(ADDR_W), .NREG(NREG)) i_decode (
        .en   (ovl_en),
        .addr (core_addr),
        .hit  (hit),
        .idx  (idx)
    );

    ovl_regfile #(.DATA_W(DATA_W), .NREG(NREG)) i_regfile (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (hit && core_we),
        .idx     (idx),
        .wr_data (core_wdata),
        .rd_data (rf_rdata)
    );

    ovl_dbg_mux #(
        .DATA_W(DATA_W), .ADDR_W(ADDR_W), .CCR_W(CCR_W), .CU_W(CU_W)
    ) i_dbg_mux (
        .sel  (dbg_sel),
        .addr (core_addr),
        .acc  (st_acc),
        .mptr (st_mptr),
        .pc   (st_pc),
        .ir   (st_ir),
        .ccr  (st_ccr),
        .cu   (st_cu),
        .dout (dbg_out)
    );

    always_comb begin
        core_rdata = hit ? rf_rdata : ext_rdata;
        pin_out    = {core_we, dbg_out};
    end
endmodule

// File: rtl/ovl_checker.sv
module ovl_checker #(
    parameter int DATA_W = 8,
    parameter int ADDR_W = 7,
    parameter int NREG   = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              ovl_en,
    input logic [2:0]        dbg_sel,
    input logic [ADDR_W-1:0] core_addr,
    input logic              core_we,
    input logic [DATA_W-1:0] core_wdata,
    input logic [DATA_W-1:0] ext_rdata,
    input logic [DATA_W-1:0] core_rdata,
    input logic [DATA_W-1:0] st_acc,
    input logic [ADDR_W:0]   pin_out
);
    localparam int BASE = (1 << ADDR_W) - NREG;
    localparam logic [ADDR_W-1:0] BASE_A = BASE[ADDR_W-1:0];

    logic past_ok;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) past_ok <= 1'b0;
        else        past_ok <= 1'b1;
    end

    assert_we_pin_R5: assert property (@(posedge clk) disable iff (!rst_n)
        pin_out[ADDR_W] == core_we);

    assert_ext_when_off_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !ovl_en |-> core_rdata == ext_rdata);

    assert_ext_below_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (ovl_en && core_addr < BASE_A) |-> core_rdata == ext_rdata);

    assert_addr_pass_R6: assert property (@(posedge clk) disable iff (!rst_n)
        dbg_sel == 3'b000 |-> pin_out[ADDR_W-1:0] == core_addr);

    assert_acc_msb_R8: assert property (@(posedge clk) disable iff (!rst_n)
        dbg_sel == 3'b010 |-> pin_out[ADDR_W-1:0] == {{(ADDR_W-1){1'b0}}, st_acc[DATA_W-1]});

    assert_write_read_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (past_ok && $past(ovl_en && core_we && core_addr >= BASE_A)
         && ovl_en && core_addr == $past(core_addr))
        |-> core_rdata == $past(core_wdata));
endmodule

bind gpr_overlay_dbg ovl_checker #(
    .DATA_W(DATA_W), .ADDR_W(ADDR_W), .NREG(NREG)
) i_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .ovl_en     (ovl_en),
    .dbg_sel    (dbg_sel),
    .core_addr  (core_addr),
    .core_we    (core_we),
    .core_wdata (core_wdata),
    .ext_rdata  (ext_rdata),
    .core_rdata (core_rdata),
    .st_acc     (st_acc),
    .pin_out    (pin_out)
);

// File: tb/test_gpr_overlay_dbg.sv
`timescale 1ns/1ps
module test_gpr_overlay_dbg;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       ovl_en = 1'b0;
    logic [2:0] dbg_sel = '0;
    logic [6:0] core_addr = '0;
    logic       core_we = 1'b0;
    logic [7:0] core_wdata = '0;
    logic [7:0] ext_rdata = '0;
    logic [7:0] core_rdata;
    logic [7:0] st_acc = '0, st_mptr = '0, st_pc = '0, st_ir = '0;
    logic [1:0] st_ccr = '0;
    logic [6:0] st_cu = '0;
    logic [7:0] pin_out;

    logic [7:0] mdl [8];
    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    gpr_overlay_dbg i_gpr_overlay_dbg (
        .clk(clk), .rst_n(rst_n), .ovl_en(ovl_en), .dbg_sel(dbg_sel),
        .core_addr(core_addr), .core_we(core_we), .core_wdata(core_wdata),
        .ext_rdata(ext_rdata), .core_rdata(core_rdata),
        .st_acc(st_acc), .st_mptr(st_mptr), .st_pc(st_pc), .st_ir(st_ir),
        .st_ccr(st_ccr), .st_cu(st_cu), .pin_out(pin_out)
    );

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic logic [6:0] exp_dbg(input logic [2:0] s);
        case (s)
            3'd0: return core_addr;
            3'd1: return st_acc[6:0];
            3'd2: return {6'd0, st_acc[7]};
            3'd3: return st_mptr[6:0];
            3'd4: return st_pc[6:0];
            3'd5: return st_ir[6:0];
            3'd6: return {5'd0, st_ccr};
            default: return st_cu;
        endcase
    endfunction

    function automatic string dbg_tag(input logic [2:0] s);
        case (s)
            3'd0: return "R6";
            3'd1: return "R7";
            3'd2: return "R8";
            3'd3: return "R9";
            3'd4, 3'd5: return "R10";
            default: return "R11";
        endcase
    endfunction

    // Drive at falling edge, sample 1 ns later, then update the model.
    task automatic step(input bit en, input bit we, input logic [6:0] a,
                        input logic [7:0] wd, input logic [2:0] s, input string rtag);
        bit hit;
        string t;
        @(negedge clk);
        ovl_en = en; core_we = we; core_addr = a; core_wdata = wd; dbg_sel = s;
        ext_rdata = 8'($urandom); st_acc = 8'($urandom); st_mptr = 8'($urandom);
        st_pc = 8'($urandom); st_ir = 8'($urandom); st_ccr = 2'($urandom);
        st_cu = 7'($urandom);
        #1;
        hit = en && (a >= 7'h78);
        t = (rtag != "") ? rtag : (hit ? "R2" : (!en ? "R3" : "R4"));
        if (hit) chk(core_rdata == mdl[a[2:0]], t, core_rdata, mdl[a[2:0]]);
        else     chk(core_rdata == ext_rdata, t, core_rdata, ext_rdata);
        chk(pin_out[6:0] == exp_dbg(s), dbg_tag(s), pin_out[6:0], exp_dbg(s));
        chk(pin_out[7] == we, "R5", pin_out[7], we);
        if (hit && we && rst_n) mdl[a[2:0]] = wd;
    endtask

    initial begin
        void'($urandom(32'd20240517));
        for (int i = 0; i < 8; i++) mdl[i] = 8'h00;
        // R1: writes during reset must not land
        repeat (3) begin
            @(negedge clk);
            ovl_en = 1'b1; core_we = 1'b1; core_addr = 7'h78; core_wdata = 8'hFF;
        end
        @(negedge clk);
        core_we = 1'b0;
        rst_n = 1'b1;
        for (int i = 0; i < 8; i++) step(1'b1, 1'b0, 7'(8'h78 + i), 8'h00, 3'd0, "R1");

        // R2: ends of the window
        step(1'b1, 1'b1, 7'h7F, 8'hA5, 3'd0, "R2");
        step(1'b1, 1'b1, 7'h78, 8'h3C, 3'd1, "R2");
        step(1'b1, 1'b0, 7'h7F, 8'h00, 3'd2, "R2");
        step(1'b1, 1'b0, 7'h78, 8'h00, 3'd3, "R2");
        // R3: disabled write to the window leaves register untouched
        step(1'b0, 1'b1, 7'h7A, 8'h99, 3'd4, "R3");
        step(1'b0, 1'b0, 7'h7A, 8'h00, 3'd5, "R3");
        step(1'b1, 1'b0, 7'h7A, 8'h00, 3'd6, "R3");
        // R4: address just below the window
        step(1'b1, 1'b1, 7'h77, 8'h55, 3'd7, "R4");
        step(1'b1, 1'b0, 7'h77, 8'h00, 3'd0, "R4");
        step(1'b1, 1'b0, 7'h7F, 8'h00, 3'd0, "R4");
        // every debug select with the write strobe high
        for (int s = 0; s < 8; s++) step(1'b1, 1'b1, 7'h10, 8'h00, 3'(s), "");

        // constrained random traffic
        for (int n = 0; n < 2000; n++) begin
            logic [6:0] a;
            a = ($urandom % 2 == 0) ? 7'(7'h78 + ($urandom % 8)) : 7'($urandom);
            step(($urandom % 4) != 0, $urandom % 2 == 1, a, 8'($urandom),
                 3'($urandom), "");
        end

        done = 1'b1;
        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual=%0d expected=%0d", 0, 1);
            $display("test done: total=%0d bad=%0d", n_chk, n_bad);
            $finish;
        end
    end
endmodule